// File: doc/BRIEF.md
# Dual-Channel Triangle Offset Sequencer

This block is the digital side of a two-channel converter front end. Software sets up both channels through a single 32-bit control word and loads a 12-bit base level into each channel's holding register. When a channel is enabled, has triggering turned on and sees a pulse on the trigger line it has selected, it takes a snapshot of its holding value plus its current triangle offset. That snapshot goes to the channel's output register exactly three clocks later, and only then does the triangle offset take its next step.

The two channels work independently. They can still select the same trigger line, and one pulse then starts both in the same cycle while each uses its own amplitude. The sum saturates at full scale. A trigger that arrives while a channel is still waiting out its latency is dropped. Turning a channel off clears its offset and its output.

Top module: `dac_tri_seq`

## Requirements
- R1: After reset the control word reads 0x0000_0000 and both channel outputs are 0.
- R2: The control word is always written whole. Channel 1 uses bits [12:0] and channel 2 uses bits [28:16], with the same layout in each half: bit 0 enable, bit 1 buffer-off flag, bit 2 trigger enable, bits [5:3] trigger line select, bits [7:6] wave mode, bits [11:8] amplitude, bit 12 DMA-request flag. Bits [15:13] and [31:29] always read 0. The buffer-off and DMA flags read back as written and have no effect on the outputs.
- R3: A channel starts a conversion only at a clock edge where its enable and trigger-enable bits are 1 and the trigger line picked by its select field is high. Pulses on the other lines, or any pulse while trigger enable is 0, leave the output unchanged.
- R4: The output register takes the new value at the third rising edge after the edge that starts the conversion, and at no other time except when the channel is disabled.
- R5: Wave mode with bit 7 of the half set (mode 1x) is triangle mode, where the captured value is holding value plus offset. With that bit clear, the captured value is the holding value alone and the offset does not move.
- R6: Amplitude n from 0 to 10 limits the offset to a peak of 2^(n+1)-1. Amplitude 11 to 15 gives a peak of 4095.
- R7: The offset starts at 0 and rises by 1 per step up to the peak. It then falls by 1 per step down to 0 and then rises again.
- R8: The offset steps once per completed conversion, after the sum is captured, so each conversion uses the offset value from before its own step.
- R9: Holding value plus offset saturates at 4095 and never wraps.
- R10: Triggers that arrive while a conversion is waiting out its latency, up to and including its transfer edge, are ignored. They start nothing and cause no extra step.
- R11: Writing 0 to a channel's enable bit clears that channel's output to 0 within one clock, and clears its offset to 0 in the rising phase.
- R12: Two channels that select the same trigger line convert on the same pulse, each following its own amplitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word write data |
| ctrl_rdata | output | 32 | Control word readback |
| hold_we | input | 2 | Holding register write strobes, bit c for channel c+1 |
| hold_wdata | input | 12 | Holding value written to every strobed channel |
| trig_in | input | 8 | Trigger lines, indexed by the select field |
| ch_out | output | 24 | Output registers: channel 1 on [11:0], channel 2 on [23:12] |

## Verification
A trigger pulse is driven on a falling edge, so the edge that starts the conversion is the next rising edge. The bench samples the outputs at the third falling edge after the pulse, where they must still hold the old value, and again at the fourth falling edge, where they must hold the new sum. The offset step is due at the same edge as the output, so the following trigger's expected sum already includes it. A control write becomes visible at the edge in the middle of the write cycle, and disabling a channel clears its output at the edge after that, which is why the disable check waits one more falling edge.

// File: rtl/dac_tri_pkg.sv
package dac_tri_pkg;

  localparam int DAC_W    = 12;
  localparam int TSEL_W   = 3;
  localparam int NUM_TRIG = 1 << TSEL_W;
  localparam int MAMP_W   = 4;
  localparam int NUM_CH   = 2;
  localparam int HALF_W   = 16;
  localparam int REG_W    = NUM_CH * HALF_W;
  localparam int LATENCY  = 3;
  localparam int PHASE_W  = $clog2(LATENCY + 1);
  localparam int FULL_AMP = 11;
  localparam logic [HALF_W-1:0] HALF_MASK = 16'h1FFF;

  typedef logic [DAC_W-1:0] sample_t;

  // one half of the control word, bit 0 at the bottom
  typedef struct packed {
    logic [2:0]        rsvd;
    logic              dma_req_en;
    logic [MAMP_W-1:0] amp_sel;
    logic [1:0]        wave_sel;
    logic [TSEL_W-1:0] trig_sel;
    logic              trig_en;
    logic              buf_off;
    logic              chan_en;
  } chan_ctl_t;

  typedef struct packed {
    logic    rising;
    sample_t level;
  } tri_state_t;

  // highest offset allowed by an amplitude code
  function automatic sample_t tri_peak(input logic [MAMP_W-1:0] amp);
    logic [DAC_W:0] p;
    if (int'(amp) >= FULL_AMP) begin
      return '1;
    end
    p = ((DAC_W+1)'(1) << ({1'b0, amp} + 5'd1)) - (DAC_W+1)'(1);
    return p[DAC_W-1:0];
  endfunction

  // clamp to full scale rather than wrap
  function automatic sample_t sat_add(input sample_t a, input sample_t b);
    logic [DAC_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DAC_W] ? '1 : s[DAC_W-1:0];
  endfunction

  // one step of the up/down walk between 0 and peak
  function automatic tri_state_t tri_advance(input tri_state_t cur, input sample_t peak);
    tri_state_t n;
    n = cur;
    if (cur.rising) begin
      if (cur.level >= peak) begin
        n.rising = 1'b0;
        n.level  = cur.level - sample_t'(1);
      end else begin
        n.level  = cur.level + sample_t'(1);
      end
    end else begin
      if (cur.level == '0) begin
        n.rising = 1'b1;
        n.level  = sample_t'(1);
      end else begin
        n.level  = cur.level - sample_t'(1);
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/dac_ctl_regs.sv
module dac_ctl_regs
  import dac_tri_pkg::*;
#(
  parameter int NCH = NUM_CH
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_i,
  input  logic [NCH*HALF_W-1:0]        wdata_i,
  output logic [NCH*HALF_W-1:0]        rdata_o,
  output logic [NCH-1:0]               en_o,
  output logic [NCH-1:0]               ten_o,
  output logic [NCH-1:0]               tri_o,
  output logic [NCH-1:0][TSEL_W-1:0]   tsel_o,
  output logic [NCH-1:0][MAMP_W-1:0]   amp_o
);

  chan_ctl_t [NCH-1:0] ctl_q;

  for (genvar c = 0; c < NCH; c++) begin : g_half
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q[c] <= '0;
      end else if (we_i) begin
        ctl_q[c] <= chan_ctl_t'(wdata_i[c*HALF_W +: HALF_W] & HALF_MASK);
      end
    end

    assign en_o[c]   = ctl_q[c].chan_en;
    assign ten_o[c]  = ctl_q[c].trig_en;
    assign tri_o[c]  = ctl_q[c].wave_sel[1];
    assign tsel_o[c] = ctl_q[c].trig_sel;
    assign amp_o[c]  = ctl_q[c].amp_sel;

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_o[c*HALF_W + 13 +: 3] == 3'b000); // R2
  end

  assign rdata_o = ctl_q;

endmodule

// File: rtl/dac_tri_gen.sv
module dac_tri_gen
  import dac_tri_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              step_i,
  input  logic [MAMP_W-1:0] amp_i,
  output sample_t           level_o
);

  tri_state_t st_q;
  tri_state_t st_nxt;
  sample_t    peak;

  always_comb begin
    peak   = tri_peak(amp_i);
    st_nxt = tri_advance(st_q, peak);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      st_q <= '{rising: 1'b1, level: '0};
    end else if (step_i) begin
      st_q <= st_nxt;
    end
  end

  assign level_o = st_q.level;

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!clr_i) && level_o != $past(level_o)) |->
      (level_o == $past(level_o) + sample_t'(1) || level_o == $past(level_o) - sample_t'(1))); // R7

  AST_STEP_ONLY_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o != $past(level_o)) |-> $past(step_i || clr_i)); // R8

endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_tri_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic                ten_i,
  input  logic                tri_i,
  input  logic [TSEL_W-1:0]   tsel_i,
  input  logic [MAMP_W-1:0]   amp_i,
  input  logic [NUM_TRIG-1:0] trig_i,
  input  sample_t             hold_i,
  output sample_t             out_o
);

  logic [PHASE_W-1:0] phase_q;
  sample_t            sum_q;
  sample_t            out_q;
  sample_t            level;
  logic               busy;
  logic               sel_hit;
  logic               launch;
  logic               xfer;

  assign busy    = phase_q != '0;
  assign sel_hit = trig_i[tsel_i];
  assign launch  = en_i & ten_i & sel_hit & ~busy;
  assign xfer    = phase_q == PHASE_W'(LATENCY);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      phase_q <= '0;
    end else if (launch) begin
      phase_q <= PHASE_W'(1);
    end else if (xfer) begin
      phase_q <= '0;
    end else if (busy) begin
      phase_q <= phase_q + PHASE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (launch) begin
      sum_q <= sat_add(hold_i, tri_i ? level : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      out_q <= '0;
    end else if (xfer) begin
      out_q <= sum_q;
    end
  end

  dac_tri_gen u_tri (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (~en_i),
    .step_i  (xfer & tri_i),
    .amp_i   (amp_i),
    .level_o (level)
  );

  assign out_o = out_q;

  AST_XFER_THREE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |-> $past(launch, 3)); // R4

  AST_OUT_MOVES_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q != $past(out_q)) |-> ($past(xfer) || !$past(en_i))); // R4

  AST_OFF_CLEARS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en_i) |-> (out_q == '0)); // R11

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (sum_q >= $past(hold_i))); // R9

endmodule

// File: rtl/dac_tri_seq.sv
module dac_tri_seq
  import dac_tri_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctrl_we,
  input  logic [REG_W-1:0]        ctrl_wdata,
  output logic [REG_W-1:0]        ctrl_rdata,
  input  logic [NUM_CH-1:0]       hold_we,
  input  logic [DAC_W-1:0]        hold_wdata,
  input  logic [NUM_TRIG-1:0]     trig_in,
  output logic [NUM_CH*DAC_W-1:0] ch_out
);

  logic [NUM_CH-1:0]             en;
  logic [NUM_CH-1:0]             ten;
  logic [NUM_CH-1:0]             tri_md;
  logic [NUM_CH-1:0][TSEL_W-1:0] tsel;
  logic [NUM_CH-1:0][MAMP_W-1:0] amp;

  dac_ctl_regs #(.NCH(NUM_CH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ctrl_we),
    .wdata_i (ctrl_wdata),
    .rdata_o (ctrl_rdata),
    .en_o    (en),
    .ten_o   (ten),
    .tri_o   (tri_md),
    .tsel_o  (tsel),
    .amp_o   (amp)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sample_t hold_q;
    sample_t out_w;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold_q <= '0;
      end else if (hold_we[c]) begin
        hold_q <= hold_wdata;
      end
    end

    dac_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en[c]),
      .ten_i  (ten[c]),
      .tri_i  (tri_md[c]),
      .tsel_i (tsel[c]),
      .amp_i  (amp[c]),
      .trig_i (trig_in),
      .hold_i (hold_q),
      .out_o  (out_w)
    );

    assign ch_out[c*DAC_W +: DAC_W] = out_w;
  end

endmodule

// File: tb/dac_tri_seq_tb_top.sv
module dac_tri_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctrl_we;
  logic [31:0] ctrl_wdata;
  logic [31:0] ctrl_rdata;
  logic [1:0]  hold_we;
  logic [11:0] hold_wdata;
  logic [7:0]  trig_in;
  logic [23:0] ch_out;

  int total = 0;
  int bad   = 0;

  // bench model of each channel
  int mhold[2];
  int mcnt[2];
  bit mup[2];
  int mout[2];
  bit men[2];
  bit mten[2];
  bit mtri[2];
  int mtsel[2];
  int mamp[2];

  always #5 clk = ~clk;

  dac_tri_seq dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .ctrl_rdata (ctrl_rdata),
    .hold_we    (hold_we),
    .hold_wdata (hold_wdata),
    .trig_in    (trig_in),
    .ch_out     (ch_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int peak_of(input int a);
    return (a >= 11) ? 4095 : (2 ** (a + 1)) - 1;
  endfunction

  function automatic logic [15:0] half(input bit en, input bit ten, input int tsel,
                                       input bit tri_on, input int amp,
                                       input bit boff, input bit dma);
    return 16'(en) | (16'(boff) << 1) | (16'(ten) << 2) | (16'(tsel) << 3)
         | (tri_on ? 16'h0080 : 16'h0000) | (16'(amp) << 8) | (16'(dma) << 12);
  endfunction

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk);
    ctrl_we = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_we = 1'b0;
    for (int c = 0; c < 2; c++) begin
      logic [15:0] h;
      h = v[c*16 +: 16];
      men[c]   = h[0];
      mten[c]  = h[2];
      mtsel[c] = int'(h[5:3]);
      mtri[c]  = h[7];
      mamp[c]  = int'(h[11:8]);
      if (!men[c]) begin
        mcnt[c] = 0;
        mup[c]  = 1'b1;
        mout[c] = 0;
      end
    end
  endtask

  task automatic wr_hold(input logic [1:0] m, input int v);
    @(negedge clk);
    hold_we = m;
    hold_wdata = 12'(v);
    @(negedge clk);
    hold_we = 2'b00;
    for (int c = 0; c < 2; c++) if (m[c]) mhold[c] = v;
  endtask

  task automatic model_step(input int c);
    if (mup[c]) begin
      if (mcnt[c] >= peak_of(mamp[c])) begin
        mup[c] = 1'b0;
        mcnt[c]--;
      end else begin
        mcnt[c]++;
      end
    end else if (mcnt[c] == 0) begin
      mup[c] = 1'b1;
      mcnt[c] = 1;
    end else begin
      mcnt[c]--;
    end
  endtask

  // pulse lines m for hold_cyc cycles, check old value at 3rd falling edge, new at 4th
  task automatic fire(input logic [7:0] m, input int hold_cyc, input string tag);
    bit go[2];
    int expv[2];
    for (int c = 0; c < 2; c++) begin
      int s;
      go[c] = men[c] && mten[c] && m[mtsel[c]];
      s = mhold[c] + (mtri[c] ? mcnt[c] : 0);
      if (s > 4095) s = 4095;
      expv[c] = go[c] ? s : mout[c];
    end
    @(negedge clk);
    trig_in = m;
    repeat (hold_cyc) @(negedge clk);
    trig_in = 8'h00;
    if (hold_cyc <= 3) begin
      repeat (3 - hold_cyc) @(negedge clk);
      chk({tag, " R4 ch1 held"}, int'(ch_out[11:0]), mout[0]);
      chk({tag, " R4 ch2 held"}, int'(ch_out[23:12]), mout[1]);
      @(negedge clk);
    end
    chk({tag, " ch1"}, int'(ch_out[11:0]), expv[0]);
    chk({tag, " ch2"}, int'(ch_out[23:12]), expv[1]);
    for (int c = 0; c < 2; c++) begin
      mout[c] = expv[c];
      if (go[c] && mtri[c]) model_step(c);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ctrl_we = 1'b0;
    ctrl_wdata = '0;
    hold_we = 2'b00;
    hold_wdata = '0;
    trig_in = 8'h00;
    for (int c = 0; c < 2; c++) begin
      mhold[c] = 0; mcnt[c] = 0; mup[c] = 1'b1; mout[c] = 0;
      men[c] = 0; mten[c] = 0; mtri[c] = 0; mtsel[c] = 0; mamp[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R1 ctrl reset", int'(ctrl_rdata), 0);
    chk("R1 out reset", int'(ch_out), 0);

    // R2: readback with reserved bits masked
    wr_ctrl(32'hFFFF_FFFF);
    chk("R2 readback", int'(ctrl_rdata), 32'h1FFF_1FFF);
    wr_ctrl(32'h0000_0000);
    chk("R2 clear readback", int'(ctrl_rdata), 0);

    wr_hold(2'b01, 100);
    wr_hold(2'b10, 2000);

    // R6 R7 R8 R12: shared line 2, different amplitudes, sweep through full periods
    for (int a = 0; a < 4; a++) begin
      wr_ctrl(32'h0);
      wr_ctrl({half(1, 1, 2, 1, a + 1, 0, 0), half(1, 1, 2, 1, a, 0, 0)});
      for (int k = 0; k < 2 * peak_of(a + 1) + 3; k++) fire(8'h04, 1, "R6 R7 R8 R12 sweep");
    end

    // R3: other lines ignored, then trigger enable off
    fire(8'hFB, 1, "R3 unselected");
    wr_ctrl({half(1, 0, 2, 1, 2, 0, 0), half(1, 0, 2, 1, 1, 0, 0)});
    fire(8'hFF, 1, "R3 ten off");

    // R5: wave bit clear gives holding value only, offset frozen
    wr_ctrl(32'h0);
    wr_ctrl({half(1, 1, 6, 0, 3, 0, 0), half(1, 1, 5, 0, 3, 0, 0)});
    fire(8'h20, 1, "R5 ch1 flat");
    fire(8'h20, 1, "R5 ch1 flat again");
    fire(8'h40, 1, "R5 ch2 flat");
    wr_ctrl({half(1, 1, 6, 1, 3, 0, 0), half(1, 1, 5, 1, 3, 0, 0)});
    fire(8'h20, 1, "R5 tri after flat");
    fire(8'h20, 1, "R5 tri step");

    // R10: trigger held through latency launches once and steps once
    wr_ctrl(32'h0);
    wr_ctrl({half(0, 0, 0, 0, 0, 0, 0), half(1, 1, 1, 1, 2, 0, 0)});
    fire(8'h02, 4, "R10 held trigger");
    chk("R10 single step", mcnt[0], 1);
    fire(8'h02, 1, "R10 next after busy");
    fire(8'h02, 3, "R10 held through transfer");
    fire(8'h02, 1, "R10 after transfer");

    // R9 with R2 flags set: saturation
    wr_ctrl(32'h0);
    wr_hold(2'b01, 4094);
    wr_hold(2'b10, 4095);
    wr_ctrl({half(1, 1, 7, 1, 0, 1, 1), half(1, 1, 7, 1, 1, 1, 1)});
    chk("R2 flags readback", int'(ctrl_rdata), int'({half(1, 1, 7, 1, 0, 1, 1), half(1, 1, 7, 1, 1, 1, 1)}));
    for (int k = 0; k < 6; k++) fire(8'h80, 1, "R9 R2 saturate");

    // R6: amplitude 12 walks beyond 2047 region start
    wr_ctrl(32'h0);
    wr_hold(2'b11, 0);
    wr_ctrl({half(1, 1, 4, 1, 11, 0, 0), half(1, 1, 4, 1, 12, 0, 0)});
    for (int k = 0; k < 5; k++) fire(8'h10, 1, "R6 large amp");

    // R11: disable clears output and offset
    wr_hold(2'b11, 50);
    fire(8'h10, 1, "R11 pre");
    wr_ctrl({half(0, 1, 4, 1, 11, 0, 0), half(0, 1, 4, 1, 12, 0, 0)});
    @(negedge clk);
    chk("R11 ch1 cleared", int'(ch_out[11:0]), 0);
    chk("R11 ch2 cleared", int'(ch_out[23:12]), 0);
    wr_ctrl({half(1, 1, 4, 1, 11, 0, 0), half(1, 1, 4, 1, 12, 0, 0)});
    fire(8'h10, 1, "R11 restart from zero");
    chk("R11 restart ch1", int'(ch_out[11:0]), 50);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule